// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the state of a parameterised set of interrupt sources and turns their input activity into offers for a set of presenters. Each source is either edge-type or level-type. Edge-type sources see a one-cycle event pulse. Level-type sources follow a line. Every source holds a destination server, a priority and a saved priority. Priority 0xFF means masked. Four status flags per source record line level, outstanding delivery, a refusal by the presenter, and an event that arrived while masked.

Offers leave one at a time on a valid/ready port. Each offer carries the server, the global source number and the priority. The presenters report back through three inputs:
- a reject, naming a source;
- an end-of-interrupt (EOI), naming a source;
- a resend request, which starts a scan over all sources.

A command port sets or reads routing and disables or re-enables a source. Each command produces a registered response with a status code.

Top module: `irqsrc_ctrl`

## Requirements
- R1: After reset every source has all flags clear, server 0, priority 0xFF and saved priority 0xFF. No offer is pending and the scan is idle.
- R2: A global source number is SRC_BASE plus the local index. A command whose number lies outside [SRC_BASE, SRC_BASE+NUM_SRC) returns status 0xFD (-3) and changes nothing. The same applies to a set-routing command (op 0) with a server at or above NUM_SRV or a priority above 0xFF. A reject or EOI naming an invalid number is ignored.
- R3: An edge event on a source whose priority is 0xFF sets its masked-pending flag and makes no offer. With any other priority the event offers the source at its server and priority.
- R4: A level source copies its line into the asserted flag. When the line changes, the source is offered if its priority is not 0xFF, asserted is set and sent is clear. Making that offer sets sent, so a line that stays high is offered once.
- R5: A reject sets the rejected flag and clears sent. An EOI clears sent for level sources only. An EOI alone never makes an offer.
- R6: During a resend scan, a level source applies the offer rule of R4. An edge source with rejected set has that flag cleared and is re-offered only if its priority is not 0xFF.
- R7: Set-routing (op 0) writes server, priority and saved priority. After any routing write, an edge source with masked-pending set and a new priority not 0xFF clears the flag and is offered. A level source applies the rule of R4.
- R8: Disable (op 2) keeps the server, writes priority 0xFF and copies the previous priority into saved priority. Enable (op 3) writes the saved priority into both fields.
- R9: Every command is answered on the next cycle by rsp_vld with code 0x00 on success. Get-routing (op 1) also returns the server and priority; the other ops return zero in those fields.
- R10: A resend scan raises scan_busy and visits one local index per cycle, from 0 upward. It does not advance while an offer is stalled. Requests that arrive during a scan cause exactly one further full pass.
- R11: Offers are presented one at a time, lowest local index first. An offer stays valid until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_kind | input | NUM_SRC | Per source: 1 = level-type, 0 = edge-type |
| src_in | input | NUM_SRC | Edge event pulse or level line per source |
| rej_vld | input | 1 | Reject notification valid |
| rej_num | input | NUM_W | Global number of the rejected source |
| eoi_vld | input | 1 | End-of-interrupt notification valid |
| eoi_num | input | NUM_W | Global number of the completed source |
| rsnd_req | input | 1 | Resend scan request |
| cmd_vld | input | 1 | Command valid |
| cmd_op | input | 2 | 0 set-routing, 1 get-routing, 2 disable, 3 enable |
| cmd_num | input | NUM_W | Global source number of the command |
| cmd_srv | input | 8 | Server for set-routing |
| cmd_pri | input | 9 | Priority for set-routing |
| rsp_vld | output | 1 | Response valid, one cycle after the command |
| rsp_code | output | 8 | 0x00 success, 0xFD invalid argument |
| rsp_srv | output | 8 | Server returned by get-routing |
| rsp_pri | output | 8 | Priority returned by get-routing |
| ofr_vld | output | 1 | Offer valid |
| ofr_rdy | input | 1 | Offer accepted by the presenter |
| ofr_srv | output | SRV_W | Destination server of the offer |
| ofr_num | output | NUM_W | Global source number of the offer |
| ofr_pri | output | 8 | Priority of the offer |
| scan_busy | output | 1 | Resend scan in progress |

## Verification
The bench builds the block with its defaults: eight sources at base 16 and four servers. It ties the upper four sources to level-type and the lower four to edge-type, so one build covers both flag behaviours and the merging of simultaneous edge offers. Base 16 places invalid numbers on both sides of the window (15 and 24). Four servers make server index 4 the first out-of-range value. With eight sources a scan lasts eight cycles, so scan length, stall holding and the merged second pass can be timed exactly at the ports.

// File: rtl/irqsrc_pkg.sv
// Shared types and constants of the interrupt source controller.
// Assumes an 8-bit priority where 0xFF means masked.
package irqsrc_pkg;

    typedef enum logic [1:0] {
        OP_ROUTE_SET = 2'd0,
        OP_ROUTE_GET = 2'd1,
        OP_MUTE      = 2'd2,
        OP_UNMUTE    = 2'd3
    } cmd_op_e;

    // Flag order: bit 3 masked-pending, bit 2 rejected, bit 1 sent, bit 0 asserted
    typedef struct packed {
        logic mpend;
        logic rejd;
        logic sent;
        logic asrt;
    } src_flags_t;

    localparam logic [7:0] PRI_OFF = 8'hFF;
    localparam logic [7:0] RSP_OK  = 8'h00;
    localparam logic [7:0] RSP_BAD = 8'hFD;

endpackage

// File: rtl/irqsrc_slot.sv
// State of one interrupt source: routing, saved priority, four flags and
// an offer-wanted bit. All stimuli of one cycle are applied in a fixed
// order: input, reject, EOI, routing write, scan visit.
// Assumes the source type (is_level) is static while out of reset.
module irqsrc_slot
    import irqsrc_pkg::*;
#(
    parameter int SRV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_level,
    input  logic             line,
    input  logic             rej_hit,
    input  logic             eoi_hit,
    input  logic             cfg_we,
    input  logic [SRV_W-1:0] cfg_srv,
    input  logic [7:0]       cfg_pri,
    input  logic [7:0]       cfg_save,
    input  logic             scan_hit,
    input  logic             grant,
    output logic [SRV_W-1:0] srv_q,
    output logic [7:0]       pri_q,
    output logic [7:0]       save_q,
    output logic             want_q
);

    src_flags_t       f_q, f_n;
    logic [SRV_W-1:0] srv_n;
    logic [7:0]       pri_n, save_n;
    logic             want_n;

    // Next-state: fold the cycle's stimuli in their fixed order
    always_comb begin
        f_n    = f_q;
        srv_n  = srv_q;
        pri_n  = pri_q;
        save_n = save_q;
        want_n = want_q & ~grant;
        if (!is_level) begin
            if (line) begin
                if (pri_n == PRI_OFF) f_n.mpend = 1'b1;
                else                  want_n    = 1'b1;
            end
        end else if (line != f_n.asrt) begin
            f_n.asrt = line;
            if (pri_n != PRI_OFF && f_n.asrt && !f_n.sent) begin
                f_n.sent = 1'b1;
                want_n   = 1'b1;
            end
        end
        if (rej_hit) begin
            f_n.rejd = 1'b1;
            f_n.sent = 1'b0;
        end
        if (eoi_hit && is_level) f_n.sent = 1'b0;
        if (cfg_we) begin
            srv_n  = cfg_srv;
            pri_n  = cfg_pri;
            save_n = cfg_save;
            if (!is_level) begin
                if (f_n.mpend && pri_n != PRI_OFF) begin
                    f_n.mpend = 1'b0;
                    want_n    = 1'b1;
                end
            end else if (pri_n != PRI_OFF && f_n.asrt && !f_n.sent) begin
                f_n.sent = 1'b1;
                want_n   = 1'b1;
            end
        end
        if (scan_hit) begin
            if (is_level) begin
                if (pri_n != PRI_OFF && f_n.asrt && !f_n.sent) begin
                    f_n.sent = 1'b1;
                    want_n   = 1'b1;
                end
            end else if (f_n.rejd) begin
                f_n.rejd = 1'b0;
                if (pri_n != PRI_OFF) want_n = 1'b1;
            end
        end
    end

    // State register with reset to masked, unrouted, no flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q    <= '0;
            srv_q  <= '0;
            pri_q  <= PRI_OFF;
            save_q <= PRI_OFF;
            want_q <= 1'b0;
        end else begin
            f_q    <= f_n;
            srv_q  <= srv_n;
            pri_q  <= pri_n;
            save_q <= save_n;
            want_q <= want_n;
        end
    end

    AST_REJ_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rej_hit && !scan_hit |=> f_q.rejd); // R5
    AST_EOI_CLEARS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_hit && is_level && !cfg_we && !scan_hit && (line == f_q.asrt) |=> !f_q.sent); // R5
    AST_MPEND_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        is_level |-> !f_q.mpend); // R3
    AST_SENT_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.sent) |-> want_q); // R4

endmodule

// File: rtl/irqsrc_pick.sv
// Fixed-priority picker: selects the lowest-index source that wants an
// offer and issues a one-hot grant when the presenter accepts.
module irqsrc_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     want,
    input  logic             rdy,
    output logic             vld,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);

    // Scan from the top so the lowest wanting index wins
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (want[i]) begin
                vld = 1'b1;
                idx = IDX_W'(i);
            end
        end
        grant = (vld && rdy) ? (N'(1) << idx) : '0;
    end

endmodule

// File: rtl/irqsrc_scan.sv
// Resend scanner: walks local indices 0..N-1, one per unstalled cycle,
// and folds requests arriving mid-scan into one further pass.
module irqsrc_scan #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic         stall,
    output logic         busy,
    output logic [N-1:0] hit
);

    logic [IDX_W-1:0] idx_q;
    logic             again_q;
    logic             adv, last;

    assign adv  = busy && !stall;
    assign last = (idx_q == IDX_W'(N - 1));
    assign hit  = adv ? (N'(1) << idx_q) : '0;

    // Scan position, busy flag and merged-rescan memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx_q   <= '0;
            again_q <= 1'b0;
        end else if (!busy) begin
            if (req) begin
                busy  <= 1'b1;
                idx_q <= '0;
            end
        end else begin
            if (req) again_q <= 1'b1;
            if (adv) begin
                if (last) begin
                    if (again_q || req) begin
                        idx_q   <= '0;
                        again_q <= 1'b0;
                    end else begin
                        busy <= 1'b0;
                    end
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    AST_SCAN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && stall |=> busy && $stable(idx_q)); // R10
    AST_SCAN_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req |=> busy && idx_q == '0); // R10

endmodule

// File: rtl/irqsrc_ctrl.sv
// Interrupt source controller top: decodes commands and presenter
// notifications onto NUM_SRC source slots, arbitrates their offers and
// drives the resend scanner. Assumes src_kind is held static after reset.
module irqsrc_ctrl
    import irqsrc_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int NUM_SRV  = 4,
    parameter int SRC_BASE = 16,
    parameter int NUM_W    = 12,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int SRV_W   = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_kind,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               rej_vld,
    input  logic [NUM_W-1:0]   rej_num,
    input  logic               eoi_vld,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               rsnd_req,
    input  logic               cmd_vld,
    input  logic [1:0]         cmd_op,
    input  logic [NUM_W-1:0]   cmd_num,
    input  logic [7:0]         cmd_srv,
    input  logic [8:0]         cmd_pri,
    output logic               rsp_vld,
    output logic [7:0]         rsp_code,
    output logic [7:0]         rsp_srv,
    output logic [7:0]         rsp_pri,
    output logic               ofr_vld,
    input  logic               ofr_rdy,
    output logic [SRV_W-1:0]   ofr_srv,
    output logic [NUM_W-1:0]   ofr_num,
    output logic [7:0]         ofr_pri,
    output logic               scan_busy
);

    logic [SRV_W-1:0]   srv_a  [NUM_SRC];
    logic [7:0]         pri_a  [NUM_SRC];
    logic [7:0]         save_a [NUM_SRC];
    logic [NUM_SRC-1:0] want, grant, scan_hit, cmd_match;
    logic [IDX_W-1:0]   pick_idx;
    logic               num_ok, cmd_bad, cmd_wr;
    logic [SRV_W-1:0]   cur_srv, wr_srv;
    logic [7:0]         cur_pri, cur_save, wr_pri, wr_save;
    cmd_op_e            op;

    assign op = cmd_op_e'(cmd_op);

    // Select the addressed slot's current routing and check the arguments
    always_comb begin
        cur_srv  = '0;
        cur_pri  = PRI_OFF;
        cur_save = PRI_OFF;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cmd_match[i]) begin
                cur_srv  = srv_a[i];
                cur_pri  = pri_a[i];
                cur_save = save_a[i];
            end
        end
        num_ok  = |cmd_match;
        cmd_bad = !num_ok || (op == OP_ROUTE_SET &&
                  (cmd_srv >= 8'(NUM_SRV) || cmd_pri > 9'd255));
        cmd_wr  = cmd_vld && !cmd_bad && op != OP_ROUTE_GET;
    end

    // Routing values a write command stores, by operation
    always_comb begin
        unique case (op)
            OP_ROUTE_SET: begin wr_srv = cmd_srv[SRV_W-1:0]; wr_pri = cmd_pri[7:0]; wr_save = cmd_pri[7:0]; end
            OP_MUTE:      begin wr_srv = cur_srv; wr_pri = PRI_OFF;  wr_save = cur_pri;  end
            OP_UNMUTE:    begin wr_srv = cur_srv; wr_pri = cur_save; wr_save = cur_save; end
            default:      begin wr_srv = cur_srv; wr_pri = cur_pri;  wr_save = cur_save; end
        endcase
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
            assign cmd_match[g] = (cmd_num == NUM_W'(SRC_BASE + g));
            irqsrc_slot #(.SRV_W(SRV_W)) i_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .is_level (src_kind[g]),
                .line     (src_in[g]),
                .rej_hit  (rej_vld && rej_num == NUM_W'(SRC_BASE + g)),
                .eoi_hit  (eoi_vld && eoi_num == NUM_W'(SRC_BASE + g)),
                .cfg_we   (cmd_wr && cmd_match[g]),
                .cfg_srv  (wr_srv),
                .cfg_pri  (wr_pri),
                .cfg_save (wr_save),
                .scan_hit (scan_hit[g]),
                .grant    (grant[g]),
                .srv_q    (srv_a[g]),
                .pri_q    (pri_a[g]),
                .save_q   (save_a[g]),
                .want_q   (want[g])
            );
        end
    endgenerate

    irqsrc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) i_pick (
        .want  (want),
        .rdy   (ofr_rdy),
        .vld   (ofr_vld),
        .idx   (pick_idx),
        .grant (grant)
    );

    assign ofr_srv = srv_a[pick_idx];
    assign ofr_pri = pri_a[pick_idx];
    assign ofr_num = NUM_W'(SRC_BASE) + NUM_W'(pick_idx);

    irqsrc_scan #(.N(NUM_SRC), .IDX_W(IDX_W)) i_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rsnd_req),
        .stall (ofr_vld && !ofr_rdy),
        .busy  (scan_busy),
        .hit   (scan_hit)
    );

    // Registered command response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            rsp_code <= RSP_OK;
            rsp_srv  <= '0;
            rsp_pri  <= '0;
        end else begin
            rsp_vld  <= cmd_vld;
            rsp_code <= cmd_bad ? RSP_BAD : RSP_OK;
            rsp_srv  <= (cmd_vld && !cmd_bad && op == OP_ROUTE_GET) ? 8'(cur_srv) : 8'h00;
            rsp_pri  <= (cmd_vld && !cmd_bad && op == OP_ROUTE_GET) ? cur_pri : 8'h00;
        end
    end

    AST_CMD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |=> rsp_vld); // R9
    AST_BAD_NUM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld && !num_ok |=> rsp_code == RSP_BAD); // R2
    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ofr_vld && !ofr_rdy |=> ofr_vld); // R11
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (ofr_vld || grant == '0)); // R11

endmodule

// File: tb/test_irqsrc_ctrl.sv
// Directed bench for irqsrc_ctrl: one task per scenario.
module test_irqsrc_ctrl;

    localparam int NS = 8, NV = 4, BASE = 16, NW = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NS-1:0] src_kind = 8'hF0, src_in = '0;
    logic rej_vld = 0, eoi_vld = 0, rsnd_req = 0, cmd_vld = 0, ofr_rdy = 1;
    logic [NW-1:0] rej_num = '0, eoi_num = '0, cmd_num = '0;
    logic [1:0] cmd_op = '0;
    logic [7:0] cmd_srv = '0;
    logic [8:0] cmd_pri = '0;
    logic rsp_vld, ofr_vld, scan_busy;
    logic [7:0] rsp_code, rsp_srv, rsp_pri, ofr_pri;
    logic [1:0] ofr_srv;
    logic [NW-1:0] ofr_num;

    int nchk = 0, nfail = 0;
    int ocnt [64];
    int opri [64];
    int osrv [64];
    bit done = 0;
    int code, rs, rp;

    always #4 clk = ~clk;

    irqsrc_ctrl #(.NUM_SRC(NS), .NUM_SRV(NV), .SRC_BASE(BASE), .NUM_W(NW)) i_irqsrc_ctrl (
        .clk(clk), .rst_n(rst_n), .src_kind(src_kind), .src_in(src_in),
        .rej_vld(rej_vld), .rej_num(rej_num), .eoi_vld(eoi_vld), .eoi_num(eoi_num),
        .rsnd_req(rsnd_req), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_num(cmd_num),
        .cmd_srv(cmd_srv), .cmd_pri(cmd_pri), .rsp_vld(rsp_vld), .rsp_code(rsp_code),
        .rsp_srv(rsp_srv), .rsp_pri(rsp_pri), .ofr_vld(ofr_vld), .ofr_rdy(ofr_rdy),
        .ofr_srv(ofr_srv), .ofr_num(ofr_num), .ofr_pri(ofr_pri), .scan_busy(scan_busy)
    );

    // Offer monitor: handshakes are counted between edges
    always @(negedge clk) begin
        if (rst_n && ofr_vld && ofr_rdy && ofr_num < 64) begin
            ocnt[ofr_num] = ocnt[ofr_num] + 1;
            opri[ofr_num] = ofr_pri;
            osrv[ofr_num] = ofr_srv;
        end
    end

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic clr();
        for (int i = 0; i < 64; i++) ocnt[i] = 0;
    endtask

    task automatic cmd(int op, int num, int srv, int pri);
        cyc();
        cmd_vld = 1; cmd_op = 2'(op); cmd_num = NW'(num); cmd_srv = 8'(srv); cmd_pri = 9'(pri);
        cyc();
        cmd_vld = 0;
        @(negedge clk);
        chk("R9 rsp_vld", rsp_vld, 1);
        code = rsp_code; rs = rsp_srv; rp = rsp_pri;
    endtask

    task automatic pulse(int idx);
        cyc(); src_in[idx] = 1'b1;
        cyc(); src_in[idx] = 1'b0;
    endtask

    task automatic reject(int num);
        cyc(); rej_vld = 1; rej_num = NW'(num);
        cyc(); rej_vld = 0;
    endtask

    task automatic eoi(int num);
        cyc(); eoi_vld = 1; eoi_num = NW'(num);
        cyc(); eoi_vld = 0;
    endtask

    task automatic resend();
        cyc(); rsnd_req = 1;
        cyc(); rsnd_req = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 no offer", ofr_vld, 0);
        chk("R1 idle scan", scan_busy, 0);
        cmd(1, 16, 0, 0);
        chk("R1 get code", code, 0); chk("R1 srv", rs, 0); chk("R1 pri", rp, 255);
        cmd(1, 23, 0, 0);
        chk("R1 pri top", rp, 255);
    endtask

    task automatic t_invalid();
        cmd(1, 15, 0, 0); chk("R2 below base", code, 8'hFD);
        cmd(1, 24, 0, 0); chk("R2 above top", code, 8'hFD);
        cmd(0, 16, 4, 1); chk("R2 bad server", code, 8'hFD);
        cmd(0, 16, 0, 256); chk("R2 bad pri", code, 8'hFD);
        cmd(1, 16, 0, 0); chk("R2 unchanged", rp, 255);
        cmd(0, 16, 2, 5); chk("R7 set ok", code, 0);
        cmd(1, 16, 0, 0); chk("R7 get srv", rs, 2); chk("R7 get pri", rp, 5);
        cmd(2, 16, 0, 0); chk("R9 non-get srv zero", rs, 0);
        cmd(3, 16, 0, 0);
    endtask

    task automatic t_edge();
        clr();
        pulse(0); idle(3);
        chk("R3 edge offer", ocnt[16], 1); chk("R3 pri", opri[16], 5); chk("R3 srv", osrv[16], 2);
        pulse(1); idle(3);
        chk("R3 masked no offer", ocnt[17], 0);
        cmd(0, 17, 1, 3); idle(2);
        chk("R7 pending offered", ocnt[17], 1); chk("R7 pri", opri[17], 3);
        cmd(0, 17, 1, 3); idle(2);
        chk("R7 pending cleared", ocnt[17], 1);
    endtask

    task automatic t_level();
        clr();
        cmd(0, 20, 3, 7); idle(2);
        chk("R4 no line no offer", ocnt[20], 0);
        cyc(); src_in[4] = 1'b1; idle(4);
        chk("R4 level offer", ocnt[20], 1); chk("R4 srv", osrv[20], 3);
        idle(5);
        chk("R4 held once", ocnt[20], 1);
        resend(); idle(12);
        chk("R6 sent blocks", ocnt[20], 1);
        eoi(20); idle(3);
        chk("R5 eoi no offer", ocnt[20], 1);
        resend(); idle(12);
        chk("R6 level reoffer", ocnt[20], 2);
        eoi(99); resend(); idle(12);
        chk("R2 invalid eoi ignored", ocnt[20], 2);
    endtask

    task automatic t_reject();
        clr();
        reject(16); resend(); idle(12);
        chk("R6 rejected replay", ocnt[16], 1); chk("R6 pri", opri[16], 5);
        resend(); idle(12);
        chk("R5 rejected cleared", ocnt[16], 1);
        reject(24); resend(); idle(12);
        chk("R2 invalid reject", ocnt[16], 1);
    endtask

    task automatic t_mute();
        clr();
        cmd(2, 16, 0, 0); chk("R8 off code", code, 0);
        cmd(1, 16, 0, 0); chk("R8 off pri", rp, 255); chk("R8 srv kept", rs, 2);
        reject(16); resend(); idle(12);
        chk("R6 masked no replay", ocnt[16], 0);
        pulse(0); idle(3);
        chk("R3 masked event", ocnt[16], 0);
        cmd(3, 16, 0, 0); idle(2);
        chk("R8 on offers pending", ocnt[16], 1); chk("R8 restored pri", opri[16], 5);
        cmd(1, 16, 0, 0); chk("R8 get pri", rp, 5);
        cmd(2, 16, 0, 0); cmd(2, 16, 0, 0); cmd(3, 16, 0, 0);
        cmd(1, 16, 0, 0); chk("R8 double off", rp, 255);
        cmd(0, 16, 2, 5);
    endtask

    task automatic t_stall();
        clr();
        cyc(); ofr_rdy = 0; src_in[0] = 1; src_in[1] = 1;
        cyc(); src_in[0] = 0; src_in[1] = 0;
        idle(2); @(negedge clk);
        chk("R11 lowest first", ofr_num, 16);
        chk("R11 held", ofr_vld, 1);
        cyc(); ofr_rdy = 1; idle(4);
        chk("R11 both out a", ocnt[16], 1); chk("R11 both out b", ocnt[17], 1);
        clr();
        reject(17);
        cyc(); ofr_rdy = 0;
        pulse(0); resend(); idle(10); @(negedge clk);
        chk("R10 scan waits", scan_busy, 1);
        chk("R10 offer stalled", ofr_num, 16);
        cyc(); ofr_rdy = 1; idle(14); @(negedge clk);
        chk("R10 scan done", scan_busy, 0);
        chk("R10 edge out", ocnt[16], 1); chk("R10 replay out", ocnt[17], 1);
    endtask

    task automatic t_scan();
        resend(); idle(7); @(negedge clk);
        chk("R10 busy 8 cycles", scan_busy, 1);
        idle(1); @(negedge clk);
        chk("R10 ends after 8", scan_busy, 0);
        resend(); idle(3); resend(); idle(5); @(negedge clk);
        chk("R10 merged rescan", scan_busy, 1);
        idle(10); @(negedge clk);
        chk("R10 merged ends", scan_busy, 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        clr();
        idle(3);
        rst_n = 1;
        t_reset();
        t_invalid();
        t_edge();
        t_level();
        t_reject();
        t_mute();
        t_stall();
        t_scan();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule